// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses, during instruction fetch, whether a conditional branch will be taken. A table of two-bit saturating counters is indexed by the low-order word-address bits of the fetch PC. Entries have no tag, so any two branches whose PCs agree in those bits share one counter. The counter value read at fetch is reduced to a single taken or not-taken bit. That bit and the table index are registered together, and the register acts as the fetch-to-decode pipeline register. The decode stage therefore sees the prediction in the cycle after the lookup.

When the branch resolves, the pipeline returns the index it was given and the actual direction. The counter at that index moves one step toward the outcome and stops at either end. Because of this hysteresis, a strongly biased entry changes its predicted direction only after two wrong guesses in a row. The table gives a direction only; target addresses come from elsewhere.

Two running counts let the accuracy of the predictor be measured: one counts lookups, the other counts resolved branches whose outcome disagreed with the entry.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry holds state 1 (weakly not taken), `dec_valid` is 0 and both counts are 0.
- R2: The table index is `lk_pc[ALIGN_W+IDX_W-1:ALIGN_W]`, which is bits 7:2 with the defaults. `dec_index` presents that index one cycle after the lookup.
- R3: `dec_valid` equals `lk_valid` of the previous cycle. `dec_taken` and `dec_index` belong to that same lookup.
- R4: A resolved taken outcome raises the addressed state by one. The state stops at 3.
- R5: A resolved not-taken outcome lowers the addressed state by one. The state stops at 0.
- R6: `dec_taken` is 1 when the entry state is 2 or 3 and 0 when it is 0 or 1. Starting from state 3, two not-taken outcomes are needed before the prediction becomes not taken.
- R7: PCs that differ only above the index bits read and update the same entry.
- R8: If a lookup and an update address the same entry in one cycle, the lookup returns the state from before the update.
- R9: `lookup_count` rises by one for each cycle with `lk_valid` high. It wraps at 2^CNT_W.
- R10: `mispredict_count` rises by one for each update whose outcome differs from the addressed entry's direction just before that update. It never rises in a cycle without an update.
- R11: With `upd_valid` low, the values on `upd_index` and `upd_taken` change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A fetch lookup is made this cycle |
| lk_pc | input | PC_W | Fetch PC |
| dec_valid | output | 1 | The decode-stage prediction is valid |
| dec_taken | output | 1 | Predicted direction (1 means taken) |
| dec_index | output | IDX_W | Table index carried with the prediction |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_index | input | IDX_W | Entry to train |
| upd_taken | input | 1 | Actual outcome (1 means taken) |
| lookup_count | output | CNT_W | Number of lookups made |
| mispredict_count | output | CNT_W | Number of updates that disagreed with their entry |

## Verification
A counter that steps the wrong way or wraps instead of saturating is not visible right away. It appears on `dec_taken` at the next lookup of that entry, one cycle after the lookup. It also appears in `mispredict_count` at the next update to that entry. Because the bench models every entry and compares all outputs on every cycle, the first lookup or update that touches a corrupted entry exposes it. Directed runs push single entries through both saturation limits, the two-miss flip, aliasing and a same-cycle read and write. These runs make a stepping error show up within two or three cycles.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'd0;
    localparam ctr_t CTR_WEAK_NT   = 2'd1;
    localparam ctr_t CTR_STRONG_T  = 2'd3;

    // Saturating step toward the observed outcome
    function automatic ctr_t ctr_step(input ctr_t s, input logic taken);
        ctr_t r;
        r = s;
        if (taken) begin
            if (s != CTR_STRONG_T) r = s + 2'd1;
        end else begin
            if (s != CTR_STRONG_NT) r = s - 2'd1;
        end
        return r;
    endfunction

    function automatic logic ctr_dir(input ctr_t s);
        return s[1];
    endfunction

endpackage

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_t             wr_old_state
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t tbl_q [ENTRIES];
    ctr_t tbl_d [ENTRIES];

    // One next-state slice per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit;
        always_comb begin
            hit      = wr_en && (wr_idx == IDX_W'(g));
            tbl_d[g] = hit ? ctr_step(tbl_q[g], wr_taken) : tbl_q[g];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q[g] <= CTR_WEAK_NT;
            else        tbl_q[g] <= tbl_d[g];
        end
    end

    // Both reads see the registered table, so a same-cycle write is not forwarded
    always_comb begin
        rd_state     = tbl_q[rd_idx];
        wr_old_state = tbl_q[wr_idx];
    end
endmodule

// File: rtl/bht_ifid.sv
module bht_ifid #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_taken,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    output logic             out_taken,
    output logic [IDX_W-1:0] out_idx
);
    typedef struct packed {
        logic             valid;
        logic             taken;
        logic [IDX_W-1:0] idx;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.taken = in_taken;
            st_d.idx   = in_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_taken = st_q.taken;
    assign out_idx   = st_q.idx;
endmodule

// File: rtl/bht_stats.sv
module bht_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_ev,
    input  logic             miss_ev,
    output logic [CNT_W-1:0] lookups,
    output logic [CNT_W-1:0] misses
);
    typedef struct packed {
        logic [CNT_W-1:0] lk;
        logic [CNT_W-1:0] ms;
    } stats_t;

    stats_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (lookup_ev) s_d.lk = s_q.lk + CNT_W'(1);
        if (miss_ev)   s_d.ms = s_q.ms + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lookups = s_q.lk;
    assign misses  = s_q.ms;
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int ALIGN_W = 2,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             dec_valid,
    output logic             dec_taken,
    output logic [IDX_W-1:0] dec_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken,
    output logic [CNT_W-1:0] lookup_count,
    output logic [CNT_W-1:0] mispredict_count
);
    localparam int IDX_LSB = ALIGN_W;
    localparam int IDX_MSB = ALIGN_W + IDX_W - 1;

    logic [IDX_W-1:0] fetch_idx;
    ctr_t             fetch_state;
    ctr_t             upd_old;
    logic             upd_miss;

    assign fetch_idx = lk_pc[IDX_MSB:IDX_LSB];
    assign upd_miss  = upd_valid && (upd_taken != ctr_dir(upd_old));

    bht_table #(.IDX_W(IDX_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (fetch_idx),
        .rd_state     (fetch_state),
        .wr_en        (upd_valid),
        .wr_idx       (upd_index),
        .wr_taken     (upd_taken),
        .wr_old_state (upd_old)
    );

    bht_ifid #(.IDX_W(IDX_W)) u_ifid (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lk_valid),
        .in_taken  (ctr_dir(fetch_state)),
        .in_idx    (fetch_idx),
        .out_valid (dec_valid),
        .out_taken (dec_taken),
        .out_idx   (dec_index)
    );

    bht_stats #(.CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .lookup_ev (lk_valid),
        .miss_ev   (upd_miss),
        .lookups   (lookup_count),
        .misses    (mispredict_count)
    );
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int ALIGN_W = 2,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [PC_W-1:0]  lk_pc,
    input logic             dec_valid,
    input logic [IDX_W-1:0] dec_index,
    input logic             upd_valid,
    input logic [CNT_W-1:0] lookup_count,
    input logic [CNT_W-1:0] mispredict_count
);
    p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> dec_valid);

    p_valid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !dec_valid);

    p_index_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> dec_index == $past(lk_pc[ALIGN_W+IDX_W-1:ALIGN_W]));

    p_lookup_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lookup_count == $past(lookup_count) + CNT_W'($past(lk_valid)));

    p_miss_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(mispredict_count));

    p_miss_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (mispredict_count - $past(mispredict_count)) <= CNT_W'(1));
endmodule

bind bht_predictor bht_predictor_chk #(
    .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .CNT_W(CNT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .lk_valid         (lk_valid),
    .lk_pc            (lk_pc),
    .dec_valid        (dec_valid),
    .dec_index        (dec_index),
    .upd_valid        (upd_valid),
    .lookup_count     (lookup_count),
    .mispredict_count (mispredict_count)
);

// File: tb/sim_bht_predictor.sv
module sim_bht_predictor;
    localparam int PC_W = 32, IDX_W = 6, ALIGN_W = 2, CNT_W = 16;
    localparam int ENT = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             dec_valid, dec_taken;
    logic [IDX_W-1:0] dec_index;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_index = '0;
    logic             upd_taken = 1'b0;
    logic [CNT_W-1:0] lookup_count, mispredict_count;

    always #2.5 clk = ~clk;

    bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .dec_valid(dec_valid), .dec_taken(dec_taken), .dec_index(dec_index),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
        .lookup_count(lookup_count), .mispredict_count(mispredict_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // Behavioural reference
    int m_state [ENT];
    int e_valid, e_taken, e_index, e_lk, e_ms;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) m_state[i] = 1;
            e_valid = 0; e_taken = 0; e_index = 0; e_lk = 0; e_ms = 0;
        end else begin
            e_valid = lk_valid;
            if (lk_valid) begin
                e_index = int'((lk_pc >> ALIGN_W) % ENT);
                e_taken = (m_state[e_index] >= 2) ? 1 : 0;
                e_lk    = (e_lk + 1) % (1 << CNT_W);
            end
            if (upd_valid) begin
                if ((upd_taken ? 1 : 0) != ((m_state[upd_index] >= 2) ? 1 : 0))
                    e_ms = (e_ms + 1) % (1 << CNT_W);
                if (upd_taken) m_state[upd_index] = (m_state[upd_index] == 3) ? 3 : m_state[upd_index] + 1;
                else           m_state[upd_index] = (m_state[upd_index] == 0) ? 0 : m_state[upd_index] - 1;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dec_valid == e_valid[0], "R3 dec_valid", dec_valid, e_valid);
            if (e_valid != 0) begin
                check(dec_taken == e_taken[0], "R6 dec_taken", dec_taken, e_taken);
                check(int'(dec_index) == e_index, "R2 dec_index", dec_index, e_index);
            end
            check(int'(lookup_count) == e_lk, "R9 lookup_count", lookup_count, e_lk);
            check(int'(mispredict_count) == e_ms, "R10 mispredict_count", mispredict_count, e_ms);
        end
    end

    // One cycle of stimulus; returns at the following falling edge
    task automatic step(input bit lv, input int pc, input bit uv, input int ui, input bit ut);
        lk_valid  = lv;
        lk_pc     = PC_W'(pc);
        upd_valid = uv;
        upd_index = IDX_W'(ui);
        upd_taken = ut;
        @(negedge clk);
    endtask

    task automatic train(input int ui, input bit ut);
        step(0, 0, 1, ui, ut);
    endtask

    task automatic probe(input int pc, input string req, input bit exp);
        step(1, pc, 0, 0, 0);
        check(dec_taken == exp, req, dec_taken, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R1 dec_valid in reset", dec_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(lookup_count == 0, "R1 lookup_count", lookup_count, 0);
        check(mispredict_count == 0, "R1 mispredict_count", mispredict_count, 0);

        // Entry 5 is at PC 20
        probe(20, "R1 weak not taken after reset", 0);
        train(5, 1);
        probe(20, "R4 one taken gives state 2", 1);
        train(5, 1); train(5, 1); train(5, 1);
        train(5, 0);
        probe(20, "R4 saturated at 3, one miss keeps taken (R6)", 1);
        train(5, 0);
        probe(20, "R6 second miss flips to not taken", 0);
        train(5, 0); train(5, 0); train(5, 0);
        train(5, 1);
        probe(20, "R5 saturated at 0, one taken stays not taken", 0);
        train(5, 1);
        probe(20 + (1 << 8), "R7 aliased PC sees shared entry", 1);
        train(9, 1);
        probe(36 + (3 << 12), "R7 alias trains entry 9", 1);
        // Entry 5 is at state 2: a not-taken update and a lookup in the same cycle
        step(1, 20, 1, 5, 0);
        check(dec_taken == 1'b1, "R8 lookup sees pre-update state", dec_taken, 1);
        probe(20, "R8 update applied afterwards", 0);
        // Entry 5 is at state 1: an update strobe held low
        step(0, 0, 0, 5, 1); step(0, 0, 0, 5, 1);
        probe(20, "R11 idle update port leaves entry", 0);

        // Random traffic over a few entries to force aliasing and collisions
        for (int k = 0; k < 2000; k++) begin
            step($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1),
                 $urandom_range(0, 7), $urandom_range(0, 1));
        end
        step(0, 0, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule